// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Controller

This block sits between a synchronous host and an asynchronous 1M x 16 pseudo-static RAM. The host issues single-word reads and writes through a valid/ready handshake. Each request carries a 20-bit word address, 16 bits of write data and two byte-enable bits. The controller drives the memory's chip enable, output enable, write enable, two byte-lane enables, the address bus and a tri-state control for its own data drivers. Read data comes back in a holding register, together with a one-cycle done pulse.

Every memory timing is a time parameter in nanoseconds. It is turned into a cycle count by rounding up against a clock-period parameter, so any clock rate meets the minimum times. After reset the controller locks out all accesses for the power-up interval and keeps chip enable high. Reads are always chip-enable controlled: the address is settled one cycle before chip enable falls. Chip enable is released after every access, so the memory's continuous-selection limit is never reached.

Top module: `psram_ctrl`

## Requirements
- R1: After reset release, `req_ready` stays low and `mem_ce_n` stays high for the power-up cycle count plus two cycles of reset synchronisation. `mem_zz_n` is high at all times.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the access and its recovery are complete, and requests seen while it is low are not taken.
- R3: A read drives the address with chip enable high for one cycle. It then holds `mem_ce_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` low and `mem_we_n` high for the read-cycle count. The address does not change while chip enable is low.
- R4: Read data is captured on the last low cycle of chip enable, and `rd_done` pulses for exactly one cycle after it. `rd_data` resets to zero and changes only when a read completes.
- R5: A write drives the address with chip enable high for one cycle. It then holds `mem_ce_n` and `mem_we_n` low and `mem_oe_n` high for the write-cycle count. `mem_lb_n` is the inverse of `req_be[0]`, which gates data bits 7:0. `mem_ub_n` is the inverse of `req_be[1]`, which gates bits 15:8.
- R6: A write ends with chip enable, write enable and both byte enables rising on the same edge, and `rd_done` pulses in the following cycle. `mem_dq_oe` is high from the fall of write enable through the hold-cycle count after it, and it is never high while `mem_oe_n` is low.
- R7: Between any two accesses, chip enable and both byte enables stay high for at least the deselect cycle count.
- R8: `mem_ce_n` is never low for more than the continuous-selection limit in cycles.
- R9: Each cycle count equals the time parameter divided by the clock period, rounded up. For example, 15 ns at a 10 ns clock gives 2 cycles.
- R10: A write with one byte enable leaves the other byte of the word unchanged. A write with neither byte enable changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rd_data | output | 16 | Last read result |
| rd_done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_zz_n | output | 1 | Power-down control, held high |
| mem_addr | output | 20 | Memory address bus |
| mem_dq_out | output | 16 | Data to the memory pins |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 16 | Data from the memory pins |

## Verification
The bench runs with a 10 ns clock and a 2000 ns power-up time, so the lockout is 200 cycles and the whole run stays short. It keeps the 70/60/15 ns access times, which makes 15 ns round up to 2 cycles and exercises the rounding rule. The memory model returns a poison value until chip enable has been low for the full read-cycle count. A controller that samples read data one cycle early therefore fails, and lane-swapped or unmasked writes show up on read-back. The 40000 ns limit becomes 4000 cycles, and the bench measures every chip-enable low run against it.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  localparam int DW = 16;

  typedef enum logic [2:0] {
    ST_LOCK, ST_IDLE, ST_ADDR, ST_READ, ST_WRITE, ST_HOLD, ST_RECOV
  } seq_state_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic ub_n;
    logic lb_n;
    logic dq_oe;
  } pin_ctl_t;

  // time in ns to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/psram_lockout.sv
module psram_lockout #(
  parameter int CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic lock_done
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          cnt_en;

  assign cnt_en = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(CYC - 1);
    else if (cnt_en) cnt_q <= cnt_q - 1'b1;
  end

  assign lock_done = !cnt_en;
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_ctrl_pkg::*;
#(
  parameter int AW       = 20,
  parameter int RD_CYC   = 7,
  parameter int WR_CYC   = 7,
  parameter int HOLD_CYC = 1,
  parameter int CD_CYC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_done,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          req_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_done,
  output pin_ctl_t      pins,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int CMAX = imax(imax(RD_CYC, WR_CYC), imax(HOLD_CYC, CD_CYC));
  localparam int CNT_W = $clog2(CMAX + 1);

  seq_state_t    st_q, st_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rd_q;
  logic [1:0]    be_q;
  logic          wr_q, done_q;
  logic          accept, capture, finish, cnt_zero;
  pin_ctl_t      pins_q, pins_nx;

  assign cnt_zero  = (cnt_q == '0);
  assign req_ready = (st_q == ST_IDLE);

  // next-state and counter
  always_comb begin
    st_nx   = st_q;
    cnt_nx  = cnt_zero ? cnt_q : cnt_q - 1'b1;
    accept  = 1'b0;
    capture = 1'b0;
    finish  = 1'b0;
    unique case (st_q)
      ST_LOCK:  if (lock_done) st_nx = ST_IDLE;
      ST_IDLE:  if (req_valid) begin
                  accept = 1'b1;
                  st_nx  = ST_ADDR;
                end
      ST_ADDR:  begin
                  st_nx  = wr_q ? ST_WRITE : ST_READ;
                  cnt_nx = wr_q ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
                end
      ST_READ:  if (cnt_zero) begin
                  capture = 1'b1;
                  finish  = 1'b1;
                  st_nx   = ST_RECOV;
                  cnt_nx  = CNT_W'(CD_CYC - 1);
                end
      ST_WRITE: if (cnt_zero) begin
                  finish = 1'b1;
                  st_nx  = ST_HOLD;
                  cnt_nx = CNT_W'(HOLD_CYC - 1);
                end
      ST_HOLD:  if (cnt_zero) begin
                  st_nx  = ST_RECOV;
                  cnt_nx = CNT_W'(CD_CYC - 1);
                end
      ST_RECOV: if (cnt_zero) st_nx = ST_IDLE;
      default:  st_nx = ST_LOCK;
    endcase
  end

  // pin decode from the next state, registered below so pins never glitch
  always_comb begin
    pins_nx.ce_n  = !((st_nx == ST_READ) || (st_nx == ST_WRITE));
    pins_nx.oe_n  = (st_nx != ST_READ);
    pins_nx.we_n  = (st_nx != ST_WRITE);
    pins_nx.ub_n  = !((st_nx == ST_READ) || ((st_nx == ST_WRITE) && be_q[1]));
    pins_nx.lb_n  = !((st_nx == ST_READ) || ((st_nx == ST_WRITE) && be_q[0]));
    pins_nx.dq_oe = (st_nx == ST_WRITE) || (st_nx == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_LOCK;
      cnt_q  <= '0;
      pins_q <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      cnt_q  <= cnt_nx;
      pins_q <= pins_nx;
      done_q <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (capture) rd_q <= mem_dq_in;
  end

  assign pins       = pins_q;
  assign rd_data    = rd_q;
  assign rd_done    = done_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int AW         = 20,
  parameter int CLK_NS     = 10,
  parameter int T_PWRUP_NS = 200000,
  parameter int T_RC_NS    = 70,
  parameter int T_AA_NS    = 70,
  parameter int T_PWE_NS   = 60,
  parameter int T_WC_NS    = 70,
  parameter int T_DH_NS    = 5,
  parameter int T_CD_NS    = 15,
  parameter int T_CEMAX_NS = 40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic [15:0]   rd_data,
  output logic          rd_done,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic          mem_zz_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);
  localparam int PWR_CYC    = ns_to_cyc(T_PWRUP_NS, CLK_NS);
  localparam int RD_CYC     = imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS));
  localparam int WR_CYC     = imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS));
  localparam int HOLD_CYC   = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int CD_CYC     = ns_to_cyc(T_CD_NS, CLK_NS);
  localparam int CE_MAX_CYC = T_CEMAX_NS / CLK_NS;

  logic     rst_n_sync;
  logic     lock_done;
  pin_ctl_t pins;

  psram_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  psram_lockout #(.CYC(PWR_CYC)) lockout_i (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .lock_done (lock_done)
  );

  psram_seq #(
    .AW(AW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC), .CD_CYC(CD_CYC)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .lock_done  (lock_done),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .req_ready  (req_ready),
    .rd_data    (rd_data),
    .rd_done    (rd_done),
    .pins       (pins),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_in  (mem_dq_in)
  );

  assign mem_ce_n  = pins.ce_n;
  assign mem_oe_n  = pins.oe_n;
  assign mem_we_n  = pins.we_n;
  assign mem_ub_n  = pins.ub_n;
  assign mem_lb_n  = pins.lb_n;
  assign mem_dq_oe = pins.dq_oe;
  assign mem_zz_n  = 1'b1;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int AW         = 20,
  parameter int CE_MAX_CYC = 4000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_done,
  input logic [15:0]   rd_data,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);
  localparam int RW = $clog2(CE_MAX_CYC + 2);

  logic [RW-1:0] ce_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  ce_run_q <= '0;
    else if (mem_ce_n)                           ce_run_q <= '0;
    else if (ce_run_q != RW'(CE_MAX_CYC + 1))    ce_run_q <= ce_run_q + 1'b1;
  end

  // R8
  ce_low_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ce_run_q) <= CE_MAX_CYC);

  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  // R6
  drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7
  ce_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> rd_done);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R5
  we_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
endmodule

bind psram_ctrl psram_ctrl_chk #(.AW(AW), .CE_MAX_CYC(CE_MAX_CYC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_done   (rd_done),
  .rd_data   (rd_data),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/psram_ctrl_tb_top.sv
module psram_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int PWR_NS = 2000;
  // expected cycle counts, rounded up by hand from the nanosecond figures
  localparam int PWC   = PWR_NS / CLK_NS;   // 200
  localparam int RDC   = 7;                 // 70 ns
  localparam int WRC   = 7;                 // max(60, 70) ns
  localparam int HDC   = 1;                 // 5 ns
  localparam int CDC   = 2;                 // 15 ns rounds up
  localparam int CEMAX = 4000;              // 40000 ns

  typedef struct packed {
    logic [6:0]  v;      // ce oe we ub lb dq done
    logic        rdchk;
    logic        wr;
    logic [15:0] rdd;
    logic [19:0] a;
    logic [15:0] wd;
  } ent_t;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic [15:0] rd_data;
  logic        rd_done;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_zz_n;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;
  logic        mem_dq_oe;

  psram_ctrl #(.CLK_NS(CLK_NS), .T_PWRUP_NS(PWR_NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_data(rd_data), .rd_done(rd_done), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_zz_n(mem_zz_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int total = 0;
  int bad   = 0;
  int pcnt  = 0;
  bit ended = 0;
  ent_t expq[$];
  logic [15:0] shadow [int];
  logic [15:0] phys [int];
  logic [15:0] last_rd = 16'h0;
  logic [15:0] model_dq = 16'hBAD0;
  int ce_run = 0;
  int rd_run = 0;
  bit pw_act = 0;
  logic [19:0] pw_a;
  logic [15:0] pw_d;
  logic pw_ub, pw_lb;

  assign mem_dq_in = model_dq;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n) pcnt <= pcnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic ent_t mk(input logic [6:0] v, input bit rc, input bit w,
                              input logic [15:0] rdd, input logic [19:0] a, input logic [15:0] wd);
    ent_t e;
    e.v = v; e.rdchk = rc; e.wr = w; e.rdd = rdd; e.a = a; e.wd = wd;
    return e;
  endfunction

  task automatic push_seq(input bit w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] cur;
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0;
    expq.push_back(mk(7'b1111100, 0, w, 0, a, d));
    if (!w) begin
      for (int i = 0; i < RDC; i++) expq.push_back(mk(7'b0010000, 0, 0, 0, a, d));
      expq.push_back(mk(7'b1111101, 1, 0, cur, a, d));
      for (int i = 1; i < CDC; i++) expq.push_back(mk(7'b1111100, 0, 0, 0, a, d));
    end else begin
      for (int i = 0; i < WRC; i++)
        expq.push_back(mk({3'b010, !be[1], !be[0], 2'b10}, 0, 1, 0, a, d));
      expq.push_back(mk(7'b1111111, 0, 1, 0, a, d));
      for (int i = 1; i < HDC; i++) expq.push_back(mk(7'b1111110, 0, 1, 0, a, d));
      for (int i = 0; i < CDC; i++) expq.push_back(mk(7'b1111100, 0, 1, 0, a, d));
      // R10 byte lanes: be[0] -> bits 7:0, be[1] -> bits 15:8
      if (be[0]) cur[7:0]  = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      shadow[int'(a)] = cur;
    end
  endtask

  // reference model and comparison, once per cycle away from the clock edge
  always @(negedge clk) begin
    ent_t e;
    bit busy, rdy_exp, wact;
    logic [6:0] act;
    string tag;
    busy = (expq.size() != 0);
    if (busy) e = expq.pop_front();
    else      e = mk(7'b1111100, 0, 0, 0, 0, 0);
    act = {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, rd_done};
    if (!busy)     tag = (pcnt < PWC + 2) ? "R1 idle pins" : "R7 idle pins";
    else if (e.wr) tag = "R5/R6/R9 write pins";
    else           tag = "R3/R4/R9 read pins";
    chk(act == e.v, tag, 32'(act), 32'(e.v));
    rdy_exp = !busy && (pcnt >= PWC + 2);
    chk(req_ready == rdy_exp, (pcnt < PWC + 2) ? "R1 ready lockout" : "R2 ready",
        32'(req_ready), 32'(rdy_exp));
    chk(mem_zz_n == 1'b1, "R1 zz high", 32'(mem_zz_n), 32'h1);
    if (busy) chk(mem_addr == e.a, "R3 address", 32'(mem_addr), 32'(e.a));
    if (busy && e.v[1]) chk(mem_dq_out == e.wd, "R5 write data", 32'(mem_dq_out), 32'(e.wd));
    if (e.rdchk) last_rd = e.rdd;
    chk(rd_data == last_rd, "R4/R10 rd_data", 32'(rd_data), 32'(last_rd));

    // R8 continuous selection run
    if (!mem_ce_n) ce_run++;
    else begin
      if (ce_run != 0) chk(ce_run <= CEMAX, "R8 ce low run", 32'(ce_run), 32'(CEMAX));
      ce_run = 0;
    end

    // memory model: commit write at its end, present read data only after full access time
    wact = !mem_ce_n && !mem_we_n && (!mem_ub_n || !mem_lb_n);
    if (pw_act && !wact) begin
      logic [15:0] w;
      w = phys.exists(int'(pw_a)) ? phys[int'(pw_a)] : 16'h0;
      if (!pw_lb) w[7:0]  = pw_d[7:0];
      if (!pw_ub) w[15:8] = pw_d[15:8];
      phys[int'(pw_a)] = w;
    end
    if (wact) begin
      pw_a = mem_addr; pw_ub = mem_ub_n; pw_lb = mem_lb_n;
      pw_d = mem_dq_oe ? mem_dq_out : 16'hEEEE;
    end
    pw_act = wact;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_run++;
    else rd_run = 0;
    if (rd_run >= RDC)
      model_dq <= phys.exists(int'(mem_addr)) ? phys[int'(mem_addr)] : 16'h0;
    else
      model_dq <= 16'hBAD0;

    if (req_valid && rdy_exp) push_seq(req_write, req_addr, req_wdata, req_be);
  end

  task automatic do_req(input bit w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; req_be = 0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1/R2: request raised during lockout waits for it to end
    do_req(1, 20'h00000, 16'h1234, 2'b11);
    do_req(1, 20'hFFFFF, 16'hA5C3, 2'b11);
    do_req(1, 20'h00010, 16'hBEEF, 2'b11);
    do_req(1, 20'h00010, 16'h7755, 2'b01);   // R10 lower only
    do_req(1, 20'h00010, 16'h12AA, 2'b10);   // R10 upper only
    do_req(1, 20'h00000, 16'hFFFF, 2'b00);   // R10 no lanes
    req_valid = 0;
    repeat (5) @(posedge clk); #1;
    do_req(0, 20'h00000, 16'h0, 2'b11);
    do_req(0, 20'hFFFFF, 16'h0, 2'b11);
    do_req(0, 20'h00010, 16'h0, 2'b00);
    do_req(0, 20'h00003, 16'h0, 2'b11);
    do_req(1, 20'h00003, 16'h0F0F, 2'b11);
    do_req(0, 20'h00003, 16'h0, 2'b11);
    req_valid = 0;
    repeat (20) @(posedge clk);
    chk(expq.size() == 0, "R2 all accesses retired", 32'(expq.size()), 32'h0);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", expq.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule